// File: doc/BRIEF.md
# No-turnaround synchronous SRAM core

This block models a synchronous static RAM whose write data trails its command by the same number of edges as its read data. A host can therefore mix reads and writes on every clock with no idle cycle between them. Address, control and byte strobes are registered on the rising clock. A live mode input picks one of two read paths. In registered mode, read data leaves an output register one edge after the address edge, and write data is taken two edges after its command. In flow-through mode, read data follows the address edge directly from the array, and write data is taken on the next edge.

A small on-chip counter produces bursts of four accesses. It uses either a wrapping increment or an XOR order on the two low address bits. A clock enable freezes the block. A sleep input parks it and keeps the array contents. An asynchronous output enable gates the drive-enable output, which stands in for a tristate bus. A read that catches a write still waiting for its data receives the merged, newest bytes.

Top module: `nbt_sram_core`

## Requirements
- R1: On an edge with cke_n low, all three chip enables active (ce1_n low, ce2 high, ce3_n low) and adv low, a new access starts at addr: a read if we_n is high, a write if we_n is low.
- R2: With flow_thru low, read data and dout_en high appear after the edge that follows the address edge. With flow_thru high, they appear right after the address edge.
- R3: Write data on din is taken two active edges after the write command when flow_thru is low, and one active edge after when flow_thru is high. Lane i is bits 9i+8..9i and is written only when bw_n[i] is low. A write with bw_n all high changes nothing.
- R4: An edge with adv high continues the previous access type at the next burst address. The bits above the low two stay fixed. The low two bits are start+k modulo 4 when burst_il is low, and start XOR k when it is high, for k = 1, 2, 3. The fifth access returns to the start address. Chip enables are ignored on such edges.
- R5: A load edge with any chip enable inactive performs no access, and its output slot has dout_en low. Continue edges after it stay deselected.
- R6: An edge with cke_n high changes no state. A read already driving keeps dout_en high and dout unchanged, and a write in flight keeps dout_en low.
- R7: sleep high at two consecutive edges puts the block asleep. While asleep, dout_en is low, all commands and write data are ignored, and the array keeps its contents. The first edge with sleep low wakes it, and the command on that edge is ignored.
- R8: On the two edges after the wake edge, reads are served but a write command is dropped. wr_err is high for exactly one cycle after each dropped write.
- R9: oe_n high forces dout_en low at once, without a clock. dout_en is also low in the output slot of every write.
- R10: A registered-mode read issued right after a write to the same address returns the write's new lanes merged with the old ones. Reads and writes may alternate on every edge.
- R11: After reset, dout_en and wr_err are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cke_n | input | 1 | Clock enable, active low |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write select, active low |
| bw_n | input | LANES | Per-lane write strobes, active low |
| adv | input | 1 | High: continue burst; low: load new address |
| burst_il | input | 1 | Burst order: 0 wrapping increment, 1 XOR |
| flow_thru | input | 1 | 1 selects flow-through read path |
| sleep | input | 1 | Sleep request, active high |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| addr | input | ADDR_W | Word address |
| din | input | LANES*LANE_W | Write data |
| dout | output | LANES*LANE_W | Read data |
| dout_en | output | 1 | Drive enable for dout |
| wr_err | output | 1 | Pulse for a write dropped during wake-up |

## Verification
The bench targets a read issued directly behind a write to the same address, with full and partial strobes, in registered mode. A design without the bypass would return the stale word there. Burst runs in both orders include a fifth access, which catches an order that uses the wrong operator or a counter that does not wrap. Clock-enable stalls land both mid-latency and after data is already driving, so a frozen pipeline that leaks an update shows up as shifted or lost data. Sleep entry and exit check that an ignored write leaves the array intact and that a write during wake-up raises wr_err instead of landing.

// File: rtl/nbt_pkg.sv
package nbt_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;
endpackage

// File: rtl/nbt_sleep_ctl.sv
module nbt_sleep_ctl #(
  parameter int ENTER_CYC = 2,
  parameter int RECOV_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sleep_in,
  output logic asleep,
  output logic recovering
);
  localparam int EW = $clog2(ENTER_CYC + 1);
  localparam int RW = $clog2(RECOV_CYC + 1);

  logic [EW-1:0] ent_q;
  logic [RW-1:0] rec_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ent_q  <= '0;
      rec_q  <= '0;
      asleep <= 1'b0;
    end else begin
      if (!sleep_in) ent_q <= '0;
      else if (ent_q != EW'(ENTER_CYC)) ent_q <= ent_q + EW'(1);

      if (!asleep && sleep_in && ent_q == EW'(ENTER_CYC - 1)) begin
        asleep <= 1'b1;
      end else if (asleep && !sleep_in) begin
        asleep <= 1'b0;
        rec_q  <= RW'(RECOV_CYC);
      end else if (rec_q != '0) begin
        rec_q <= rec_q - RW'(1);
      end
    end
  end

  assign recovering = (rec_q != '0);

  // R7: sleep is only entered while the request is held
  assert_entry_held_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(asleep) |-> $past(sleep_in));

  // R8: leaving sleep always opens the wake-up window
  assert_wake_window_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(asleep) |-> recovering);
endmodule

// File: rtl/nbt_burst_gen.sv
module nbt_burst_gen import nbt_pkg::*; #(
  parameter int ADDR_W  = 6,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              load,
  input  logic              sel,
  input  logic              wr_req,
  input  logic              block_wr,
  input  logic              force_idle,
  input  logic              il,
  input  logic [ADDR_W-1:0] addr_in,
  output op_e               op_nx,
  output logic [ADDR_W-1:0] addr_nx,
  output logic              wr_reject
);
  localparam int HW = ADDR_W - BURST_W;

  op_e                op_q;
  logic [HW-1:0]      hi_q;
  logic [BURST_W-1:0] base_q;
  logic [BURST_W-1:0] cnt_q;
  logic [BURST_W-1:0] cnt_nx;
  logic [BURST_W-1:0] lo_nx;

  always_comb begin
    wr_reject = load && sel && wr_req && block_wr && !force_idle;
    cnt_nx    = cnt_q + BURST_W'(1);
    lo_nx     = il ? (base_q ^ cnt_nx) : (base_q + cnt_nx);
    if (force_idle) begin
      op_nx   = OP_IDLE;
      cnt_nx  = cnt_q;
      addr_nx = {hi_q, base_q};
    end else if (load) begin
      op_nx   = (!sel || wr_reject) ? OP_IDLE : (wr_req ? OP_WR : OP_RD);
      cnt_nx  = '0;
      addr_nx = addr_in;
    end else begin
      op_nx   = op_q;
      addr_nx = {hi_q, lo_nx};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q   <= OP_IDLE;
      hi_q   <= '0;
      base_q <= '0;
      cnt_q  <= '0;
    end else if (en) begin
      op_q  <= op_nx;
      cnt_q <= cnt_nx;
      if (load && !force_idle) begin
        hi_q   <= addr_in[ADDR_W-1:BURST_W];
        base_q <= addr_in[BURST_W-1:0];
      end
    end
  end

  // R1: a selected load with write select high starts a read
  assert_load_read_R1: assert property (@(posedge clk) disable iff (rst)
    (en && load && sel && !wr_req && !force_idle) |=> op_q == OP_RD);

  // R5: continuing from a deselected state stays deselected
  assert_desel_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    (en && !load && op_q == OP_IDLE) |=> op_q == OP_IDLE);
endmodule

// File: rtl/nbt_store.sv
module nbt_store #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [LANES-1:0]        wr_mask,
  input  logic [LANES*LANE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0]       rd_addr,
  input  logic                    fwd_en,
  input  logic [LANES-1:0]        fwd_mask,
  input  logic [LANES*LANE_W-1:0] fwd_data,
  output logic [LANES*LANE_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] bank [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en && wr_mask[g]) bank[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
    end

    assign rd_data[g*LANE_W +: LANE_W] = (fwd_en && fwd_mask[g]) ?
                                         fwd_data[g*LANE_W +: LANE_W] :
                                         bank[rd_addr];
  end
endmodule

// File: rtl/nbt_sram_core.sv
module nbt_sram_core import nbt_pkg::*; #(
  parameter int ADDR_W    = 6,
  parameter int LANES     = 2,
  parameter int LANE_W    = 9,
  parameter int BURST_W   = 2,
  parameter int ENTER_CYC = 2,
  parameter int RECOV_CYC = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cke_n,
  input  logic                    ce1_n,
  input  logic                    ce2,
  input  logic                    ce3_n,
  input  logic                    we_n,
  input  logic [LANES-1:0]        bw_n,
  input  logic                    adv,
  input  logic                    burst_il,
  input  logic                    flow_thru,
  input  logic                    sleep,
  input  logic                    oe_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] din,
  output logic [LANES*LANE_W-1:0] dout,
  output logic                    dout_en,
  output logic                    wr_err
);
  localparam int DW = LANES * LANE_W;

  logic              asleep, recovering;
  logic              cke_act, adv_en, sel, wr_reject;
  op_e               op_nx, op1, op2;
  logic [ADDR_W-1:0] addr_nx, a1, a2;
  logic [LANES-1:0]  m1, m2;
  logic              wr_en, fwd_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [LANES-1:0]  wr_mask;
  logic [DW-1:0]     rd_data, out_q;

  assign cke_act = !cke_n && !asleep;
  assign adv_en  = !cke_n || asleep;
  assign sel     = !ce1_n && ce2 && !ce3_n;

  nbt_sleep_ctl #(.ENTER_CYC(ENTER_CYC), .RECOV_CYC(RECOV_CYC)) u_sleep (
    .clk(clk), .rst(rst), .sleep_in(sleep),
    .asleep(asleep), .recovering(recovering)
  );

  nbt_burst_gen #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_burst (
    .clk(clk), .rst(rst), .en(adv_en), .load(!adv), .sel(sel),
    .wr_req(!we_n), .block_wr(recovering), .force_idle(asleep),
    .il(burst_il), .addr_in(addr),
    .op_nx(op_nx), .addr_nx(addr_nx), .wr_reject(wr_reject)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      op1    <= OP_IDLE;
      op2    <= OP_IDLE;
      a1     <= '0;
      a2     <= '0;
      m1     <= '0;
      m2     <= '0;
      out_q  <= '0;
      wr_err <= 1'b0;
    end else begin
      wr_err <= cke_act && wr_reject;
      if (adv_en) begin
        op1 <= op_nx;
        a1  <= addr_nx;
        m1  <= ~bw_n;
        op2 <= op1;
        a2  <= a1;
        m2  <= m1;
      end
      if (cke_act) out_q <= rd_data;
    end
  end

  always_comb begin
    wr_en   = cke_act && (flow_thru ? (op1 == OP_WR) : (op2 == OP_WR));
    wr_addr = flow_thru ? a1 : a2;
    wr_mask = flow_thru ? m1 : m2;
    fwd_en  = !flow_thru && op2 == OP_WR && op1 == OP_RD && a2 == a1;
  end

  nbt_store #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_store (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_mask(wr_mask),
    .wr_data(din), .rd_addr(a1), .fwd_en(fwd_en), .fwd_mask(m2),
    .fwd_data(din), .rd_data(rd_data)
  );

  assign dout    = flow_thru ? rd_data : out_q;
  assign dout_en = !oe_n && !asleep &&
                   (flow_thru ? (op1 == OP_RD) : (op2 == OP_RD));

  // R5: a deselecting load leaves no access in the first stage
  assert_desel_load_R5: assert property (@(posedge clk) disable iff (rst)
    (cke_act && !adv && !sel) |=> op1 == OP_IDLE);

  // R6: a stalled edge moves neither the command stage nor the output register
  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (cke_n && !asleep) |=> ($stable(op1) && $stable(a1) && $stable(out_q)));

  // R7: nothing is driven and nothing is written while asleep
  assert_sleep_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    asleep |-> (!dout_en && !wr_en));

  // R8: a write during wake-up is dropped and flagged
  assert_wake_reject_R8: assert property (@(posedge clk) disable iff (rst)
    (cke_act && recovering && !adv && sel && !we_n) |=> (op1 != OP_WR && wr_err));

  // R9: the write slot in flow-through never drives
  assert_write_slot_off_R9: assert property (@(posedge clk) disable iff (rst)
    (flow_thru && op1 == OP_WR) |-> !dout_en);
endmodule

// File: tb/tb_nbt_sram_core.sv
module tb_nbt_sram_core;
  localparam int AW = 6;
  localparam int DW = 18;

  logic          clk = 1'b0;
  logic          rst, cke_n, ce1_n, ce2, ce3_n, we_n, adv, burst_il, flow_thru, sleep, oe_n;
  logic [1:0]    bw_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] din, dout;
  logic          dout_en, wr_err;

  nbt_sram_core dut (.*);

  always #4 clk = ~clk;

  typedef struct { int at; bit en; int adr; string tag; } exp_t;
  typedef struct { int at; int adr; logic [1:0] m; logic [DW-1:0] d; } pw_t;
  exp_t expq[$];
  pw_t  pwq[$];
  logic [DW-1:0] mm [64];

  int act = 0, total = 0, bad = 0, lat_rd = 1, lat_wr = 2;
  int op_kind = 0, op_adr = 0;
  logic [DW-1:0] op_d = '0;
  string op_tag = "R5";
  bit done = 0;

  function automatic logic [DW-1:0] pat(int i);
    return DW'(i * 18'h0A5A3 + 18'h01234);
  endfunction

  function automatic int badr(int start, int k, bit il);
    int lo = start & 3;
    int nl = il ? (lo ^ (k & 3)) : ((lo + k) & 3);
    return (start & ~3) | nl;
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] got, logic [31:0] want);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, want);
    end
  endtask

  // monitor: pops expected items once their slot is reached
  always @(negedge clk) begin
    while (expq.size() > 0 && expq[0].at == act) begin
      exp_t e;
      e = expq.pop_front();
      if (e.en)
        chk(dout_en === 1'b1 && dout === mm[e.adr], e.tag,
            {13'd0, dout_en, dout}, {13'd0, 1'b1, mm[e.adr]});
      else
        chk(dout_en === 1'b0, e.tag, {31'd0, dout_en}, 32'd0);
    end
  end

  // driver: one edge; model advances on active edges
  task automatic cyc();
    if (pwq.size() > 0 && pwq[0].at == act + 1) din = pwq[0].d;
    else din = '0;
    @(posedge clk);
    if (!cke_n) begin
      act++;
      if (pwq.size() > 0 && pwq[0].at == act) begin
        for (int l = 0; l < 2; l++)
          if (pwq[0].m[l]) mm[pwq[0].adr][l*9 +: 9] = pwq[0].d[l*9 +: 9];
        void'(pwq.pop_front());
      end
      if (op_kind == 1) expq.push_back('{act + lat_rd, 1'b1, op_adr, op_tag});
      else begin
        if (op_kind == 2) pwq.push_back('{act + lat_wr, op_adr, ~bw_n, op_d});
        expq.push_back('{act + lat_rd, 1'b0, 0, op_tag});
      end
    end
    #2;
  endtask

  task automatic rawcyc();
    @(posedge clk);
    #2;
  endtask

  task automatic set_idle();
    cke_n = 0; ce1_n = 1; ce2 = 1; ce3_n = 0; adv = 0; we_n = 1; bw_n = 2'b11;
    addr = '0; op_kind = 0; op_tag = "R5";
  endtask

  task automatic idle(int n);
    set_idle();
    repeat (n) cyc();
  endtask

  task automatic rd(int a, string t);
    cke_n = 0; ce1_n = 0; ce2 = 1; ce3_n = 0; adv = 0; we_n = 1; bw_n = 2'b11;
    addr = AW'(a); op_kind = 1; op_adr = a; op_tag = t;
    cyc();
  endtask

  task automatic wr(int a, logic [1:0] bwn, logic [DW-1:0] d, string t);
    cke_n = 0; ce1_n = 0; ce2 = 1; ce3_n = 0; adv = 0; we_n = 0; bw_n = bwn;
    addr = AW'(a); op_kind = 2; op_adr = a; op_d = d; op_tag = t;
    cyc();
  endtask

  // continue: chip enables deliberately inactive, they must not matter
  task automatic cont(int kind, int a, logic [DW-1:0] d, string t);
    cke_n = 0; ce1_n = 1; ce2 = 0; ce3_n = 1; adv = 1; we_n = 1; bw_n = 2'b00;
    addr = '0; op_kind = kind; op_adr = a; op_d = d; op_tag = t;
    cyc();
  endtask

  task automatic probe(bit en_exp, logic [DW-1:0] d_exp, string t);
    @(negedge clk);
    if (en_exp)
      chk(dout_en === 1'b1 && dout === d_exp, t, {13'd0, dout_en, dout}, {13'd0, 1'b1, d_exp});
    else
      chk(dout_en === 1'b0, t, {31'd0, dout_en}, 32'd0);
  endtask

  task automatic finish_run();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got hang expected completion");
      finish_run();
    end
  end

  initial begin
    rst = 1; flow_thru = 0; burst_il = 0; sleep = 0; oe_n = 0; din = '0;
    set_idle();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(dout_en === 1'b0, "R11", {31'd0, dout_en}, 32'd0);
    chk(wr_err === 1'b0, "R11", {31'd0, wr_err}, 32'd0);
    @(posedge clk); #2 rst = 0;

    // registered mode: fill and read back (R1, R2, R3)
    for (int i = 0; i < 16; i++) wr(i, 2'b00, pat(i), "R3");
    idle(3);
    for (int i = 0; i < 16; i++) rd(i, (i < 8) ? "R1" : "R2");

    // alternating write/read to one address each, no gap (R10)
    for (int i = 0; i < 6; i++) begin
      wr(20 + i, 2'b00, pat(100 + i), "R10");
      rd(20 + i, "R10");
    end
    rd(3, "R10"); wr(4, 2'b00, pat(50), "R10"); rd(4, "R10");

    // partial lane write with bypass, and abort (R3, R10)
    wr(30, 2'b00, pat(60), "R3");
    wr(30, 2'b10, pat(61), "R3");
    rd(30, "R10");
    wr(31, 2'b00, pat(62), "R3");
    idle(2);
    wr(31, 2'b11, pat(63), "R3");
    idle(3);
    rd(31, "R3");

    // bursts in both orders, including wrap (R4)
    idle(2);
    burst_il = 0;
    wr(badr(18, 0, 0), 2'b00, pat(70), "R4");
    for (int k = 1; k < 4; k++) cont(2, badr(18, k, 0), pat(70 + k), "R4");
    idle(3);
    burst_il = 1;
    rd(badr(17, 0, 1), "R4");
    for (int k = 1; k < 5; k++) cont(1, badr(17, k, 1), '0, "R4");
    burst_il = 0;
    rd(badr(19, 0, 0), "R4");
    for (int k = 1; k < 5; k++) cont(1, badr(19, k, 0), '0, "R4");

    // deselect on each enable, then a continue that stays deselected (R5)
    idle(2);
    for (int v = 0; v < 3; v++) begin
      cke_n = 0; adv = 0; we_n = 0; bw_n = 2'b00; addr = AW'(5);
      ce1_n = (v == 0); ce2 = (v != 1); ce3_n = (v == 2);
      op_kind = 0; op_tag = "R5";
      cyc();
      cont(0, 0, '0, "R5");
    end
    idle(3);
    rd(5, "R5");

    // stall mid-latency, stall while driving, stall on a write (R6)
    idle(2);
    rd(7, "R6");
    cke_n = 1; adv = 0; ce1_n = 0; ce2 = 1; ce3_n = 0; we_n = 0; bw_n = 2'b00; addr = AW'(7);
    cyc();
    idle(1);
    for (int s = 0; s < 3; s++) begin
      cke_n = 1; we_n = 0; ce1_n = 0; addr = AW'(7);
      cyc();
      probe(1'b1, mm[7], "R6");
    end
    wr(8, 2'b00, pat(80), "R6");
    cke_n = 1;
    cyc();
    probe(1'b0, '0, "R6");
    idle(3);
    rd(8, "R6");

    // output enable gating without a clock (R9)
    idle(2);
    rd(9, "R9");
    idle(1);
    @(negedge clk);
    #1 oe_n = 1;
    #1 chk(dout_en === 1'b0, "R9", {31'd0, dout_en}, 32'd0);
    oe_n = 0;
    #1 chk(dout_en === 1'b1, "R9", {31'd0, dout_en}, 32'd1);
    @(posedge clk); #2;

    // flow-through mode (R2, R3, R4, R6, R9)
    idle(3);
    flow_thru = 1; lat_rd = 0; lat_wr = 1;
    idle(2);
    for (int i = 0; i < 4; i++) begin
      wr(40 + i, 2'b00, pat(200 + i), "R9");
      rd(40 + i, "R3");
      rd(i, "R2");
    end
    wr(41, 2'b01, pat(210), "R3");
    rd(41, "R3");
    rd(3, "R6");
    cke_n = 1;
    cyc();
    probe(1'b1, mm[3], "R6");
    burst_il = 1;
    rd(badr(18, 0, 1), "R4");
    for (int k = 1; k < 4; k++) cont(1, badr(18, k, 1), '0, "R4");
    burst_il = 0;

    // sleep entry, ignored commands, wake-up window (R7, R8)
    idle(3);
    sleep = 1;
    set_idle();
    rawcyc(); rawcyc();
    ce1_n = 0; adv = 0; we_n = 1; addr = AW'(1);
    rawcyc();
    probe(1'b0, '0, "R7");
    we_n = 0; bw_n = 2'b00; addr = AW'(1); din = pat(300);
    rawcyc();
    din = pat(301);
    probe(1'b0, '0, "R7");
    sleep = 0;
    we_n = 1; addr = AW'(2);
    rawcyc();
    probe(1'b0, '0, "R7");
    we_n = 0; bw_n = 2'b00; addr = AW'(2); din = pat(302);
    rawcyc();
    @(negedge clk);
    chk(wr_err === 1'b1, "R8", {31'd0, wr_err}, 32'd1);
    rd(1, "R7");
    @(negedge clk);
    chk(wr_err === 1'b0, "R8", {31'd0, wr_err}, 32'd0);
    rd(2, "R8");
    idle(3);

    finish_run();
  end
endmodule